// File: doc/BRIEF.md
# Bidirectional Pin Bank with Change Detection

This block is an 8-bit general-purpose pin bank. Every pin can be an input or an output, set by its own direction bit. Output pins drive a stored data latch. Input pins can have a weak pull-up, and one shared control bit, active low, turns those pull-ups on. Each pad is presented as three signals: an input value, an output value and an output enable. There is also a pull-up enable for each pin.

The pad inputs pass through a two-flop synchroniser. The port read path and the change detector both use the synchronised values. The upper four pins are watched for change, but only while they are inputs. The detector compares each watched pin with a snapshot. That snapshot is taken whenever software reads or writes the port data register.

Any difference raises a sticky change flag. While the difference remains, the flag rises again even after software clears it. The usual service sequence is therefore: access the port first, then clear the flag. A wake request output mirrors the flag. Interrupt enable gating is done outside the block.

Top module: `pinbank_port`

## Requirements
- R1: During and after reset the state is: output latch 0, every direction bit 1 (input), pull-up control 1 (disabled), change flag 0. Hence pad_out is 0, pad_oe is 0 and pad_pull is 0. The flag register reads the flag in bit 0 and zeros above it.
- R2: A bus write to address 0 stores bus_wdata in the output latch. pad_out shows it after that clock edge.
- R3: A bus write to address 1 stores the direction register. A 1 bit means input and a 0 bit means output. pad_oe is the bitwise inverse of the direction register. A read at address 1 returns the register.
- R4: Address 2, bit 0 is the pull-up control. When this bit is 0, pad_pull[i] equals direction bit i. When it is 1, pad_pull is all zero. A pin driven as an output never has its pull-up on.
- R5: A read of address 0 returns the pad inputs after two synchronising flops. A pad change is visible in bus_rdata after the second clock edge that follows it.
- R6: Pins 7 to 4, while configured as inputs, are compared with the snapshot. Any difference sets chg_flag at the next edge. So a pad change held steady raises the flag after the third clock edge.
- R7: Pins 3 to 0, and any of pins 7 to 4 configured as outputs, never set chg_flag.
- R8: The flag is sticky. Writing address 3 with bus_wdata bit 0 set clears it. If a difference still exists in the same cycle, setting wins and the flag stays 1.
- R9: A read or a write of address 0 copies the synchronised pins 7 to 4 into the snapshot. After that, a clear leaves the flag at 0 until the pins differ again.
- R10: wake_req equals chg_flag in every cycle.
- R11: During the first three clock edges after reset, the snapshot follows the synchronised pins and the flag is not set. Pin levels present at reset therefore raise no flag.

Addresses: 0 is port data, 1 is direction, 2 is pull-up control, 3 is change flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read of address 0 retakes the snapshot) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | 8 | Pad input values, asynchronous |
| pad_out | output | 8 | Pad output values (the output latch) |
| pad_oe | output | 8 | Pad output enables, 1 drives the pad |
| pad_pull | output | 8 | Weak pull-up enable per pad |
| chg_flag | output | 1 | Sticky change flag |
| wake_req | output | 1 | Wake request, follows the flag |

## Verification
A stale or corrupted snapshot shows at chg_flag. The flag either rises with no pad change, or fails to rise on the third edge after a change. A fault in the settling counter shows as a spurious flag within three edges of reset when the pads are non-zero.

A wrong direction or latch bit shows on pad_oe, pad_out and pad_pull one edge after the write. A synchroniser of the wrong depth moves the port read value one edge early or late.

The bench's reference model checks every output on every cycle, so any such deviation is caught on the cycle it first appears.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
    localparam int PB_WIDTH   = 8;
    localparam int PB_CHG_LO  = 4;
    localparam int PB_SYNC    = 2;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_CTRL = 2'd2,
        REG_FLAG = 2'd3
    } pb_reg_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/pinbank_chg.sv
module pinbank_chg #(
    parameter int W      = 4,
    parameter int SETTLE = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] watch,
    input  logic         access,
    input  logic         clear,
    output logic         flag
);
    localparam int CW = $clog2(SETTLE + 1);

    typedef struct packed {
        logic [W-1:0]  snap;
        logic          flag;
        logic [CW-1:0] settle;
    } chg_st_t;

    chg_st_t st_d, st_q;
    logic    settled;
    logic    mismatch;

    always_comb begin
        settled  = (st_q.settle == CW'(SETTLE));
        mismatch = |((pins ^ st_q.snap) & watch);
        st_d     = st_q;
        if (!settled) begin
            st_d.settle = st_q.settle + CW'(1);
            st_d.snap   = pins;
            st_d.flag   = st_q.flag & ~clear;
        end else begin
            if (access) st_d.snap = pins;
            st_d.flag = mismatch | (st_q.flag & ~clear);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/pinbank_port.sv
module pinbank_port
    import pinbank_pkg::*;
#(
    parameter int WIDTH  = PB_WIDTH,
    parameter int CHG_LO = PB_CHG_LO,
    parameter int SYNC   = PB_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pull,
    output logic             chg_flag,
    output logic             wake_req
);
    localparam int CHG_W = WIDTH - CHG_LO;

    typedef struct packed {
        logic [WIDTH-1:0] lat;
        logic [WIDTH-1:0] dir;
        logic             pu_off;
    } port_st_t;

    port_st_t         rg_d, rg_q;
    logic [WIDTH-1:0] pins_s;
    logic             port_access;
    logic             flag_clear;

    pinbank_sync #(.W(WIDTH), .STAGES(SYNC)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pins_s)
    );

    assign port_access = (bus_wr | bus_rd) && (bus_addr == REG_DATA);
    assign flag_clear  = bus_wr && (bus_addr == REG_FLAG) && bus_wdata[0];

    pinbank_chg #(.W(CHG_W), .SETTLE(SYNC + 1)) i_chg (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins   (pins_s[WIDTH-1:CHG_LO]),
        .watch  (rg_q.dir[WIDTH-1:CHG_LO]),
        .access (port_access),
        .clear  (flag_clear),
        .flag   (chg_flag)
    );

    always_comb begin
        rg_d = rg_q;
        if (bus_wr) begin
            case (bus_addr)
                REG_DATA: rg_d.lat    = bus_wdata;
                REG_DIR:  rg_d.dir    = bus_wdata;
                REG_CTRL: rg_d.pu_off = bus_wdata[0];
                default:  rg_d        = rg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.lat    <= '0;
            rg_q.dir    <= '1;
            rg_q.pu_off <= 1'b1;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        case (bus_addr)
            REG_DATA: bus_rdata = pins_s;
            REG_DIR:  bus_rdata = rg_q.dir;
            REG_CTRL: bus_rdata = {{(WIDTH-1){1'b0}}, rg_q.pu_off};
            default:  bus_rdata = {{(WIDTH-1){1'b0}}, chg_flag};
        endcase
    end

    assign pad_out  = rg_q.lat;
    assign pad_oe   = ~rg_q.dir;
    assign pad_pull = {WIDTH{~rg_q.pu_off}} & rg_q.dir;
    assign wake_req = chg_flag;
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk
    import pinbank_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          bus_addr,
    input logic                bus_wr,
    input logic [PB_WIDTH-1:0] bus_wdata,
    input logic [PB_WIDTH-1:0] pad_out,
    input logic [PB_WIDTH-1:0] pad_oe,
    input logic [PB_WIDTH-1:0] pad_pull,
    input logic                chg_flag
);
    logic [2:0] edges_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edges_q <= '0;
        else if (edges_q != 3'd4) edges_q <= edges_q + 3'd1;
    end

    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DATA) |=> pad_out == $past(bus_wdata)); // R2

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DIR) |=> pad_oe == ~$past(bus_wdata)); // R3

    AST_PULL_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull & pad_oe) == '0); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag && !(bus_wr && bus_addr == REG_FLAG && bus_wdata[0])) |=> chg_flag); // R8

    AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q <= 3'd3) |-> !chg_flag); // R11
endmodule

bind pinbank_port pinbank_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pull  (pad_pull),
    .chg_flag  (chg_flag)
);

// File: tb/test_pinbank_port.sv
module test_pinbank_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'hA5;
    logic [7:0] pad_out, pad_oe, pad_pull;
    logic       chg_flag, wake_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pinbank_port i_pinbank_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull(pad_pull), .chg_flag(chg_flag), .wake_req(wake_req)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: registers updated per edge from the requirements
    logic [7:0] m_lat, m_dir, m_sync;
    logic       m_pud, m_flag;
    logic [3:0] m_snap;
    int         m_edges;
    logic [7:0] m_hist[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lat = 8'h00; m_dir = 8'hFF; m_pud = 1'b1; m_flag = 1'b0;
            m_snap = 4'h0; m_edges = 0; m_hist = '{8'h00, 8'h00};
        end else begin
            logic acc, clr, mism, nflag;
            logic [3:0] nsnap;
            m_sync = m_hist[0];
            acc  = (bus_wr || bus_rd) && bus_addr == 2'd0;
            clr  = bus_wr && bus_addr == 2'd3 && bus_wdata[0];
            mism = 1'b0;
            for (int b = 4; b < 8; b++)
                if (m_dir[b] && m_sync[b] != m_snap[b-4]) mism = 1'b1;
            if (m_edges < 3) begin
                nflag = m_flag && !clr;
                nsnap = m_sync[7:4];
                m_edges++;
            end else begin
                nflag = mism || (m_flag && !clr);
                nsnap = acc ? m_sync[7:4] : m_snap;
            end
            if (bus_wr && bus_addr == 2'd0) m_lat = bus_wdata;
            if (bus_wr && bus_addr == 2'd1) m_dir = bus_wdata;
            if (bus_wr && bus_addr == 2'd2) m_pud = bus_wdata[0];
            m_flag = nflag;
            m_snap = nsnap;
            m_hist.push_back(pad_in);
            void'(m_hist.pop_front());
        end
        m_sync = m_hist[0];
        #2;
        if (!done) begin
            logic [7:0] exp_rd;
            case (bus_addr)
                2'd0: exp_rd = m_sync;
                2'd1: exp_rd = m_dir;
                2'd2: exp_rd = {7'd0, m_pud};
                default: exp_rd = {7'd0, m_flag};
            endcase
            check("R2 model pad_out", pad_out, m_lat);
            check("R3 model pad_oe", pad_oe, ~m_dir);
            check("R4 model pad_pull", pad_pull, m_pud ? 8'h00 : m_dir);
            check("R6 model chg_flag", {7'd0, chg_flag}, {7'd0, m_flag});
            check("R10 model wake_req", {7'd0, wake_req}, {7'd0, m_flag});
            check("R5 model bus_rdata", bus_rdata, exp_rd);
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        cyc(3);
        check("R1 reset pad_out", pad_out, 8'h00);
        check("R1 reset pad_oe", pad_oe, 8'h00);
        check("R1 reset pad_pull", pad_pull, 8'h00);
        check("R1 reset flag", {7'd0, chg_flag}, 8'h00);
        bus_addr = 2'd1; #1 check("R1 reset dir read", bus_rdata, 8'hFF);
        bus_addr = 2'd2; #1 check("R1 reset ctrl read", bus_rdata, 8'h01);
        bus_addr = 2'd0;
        @(negedge clk); rst_n = 1'b1;
        cyc(6);
        check("R11 no flag from reset levels", {7'd0, chg_flag}, 8'h00);
        bus_read(2'd0, rd);
        check("R5 port read", rd, 8'hA5);

        // latency of synchroniser and detector
        @(negedge clk); pad_in = 8'h5A;
        @(negedge clk); #1 check("R5 one edge old value", bus_rdata, 8'hA5);
        @(negedge clk); #1 check("R5 two edges new value", bus_rdata, 8'h5A);
        check("R6 flag not yet", {7'd0, chg_flag}, 8'h00);
        @(negedge clk); check("R6 flag on third edge", {7'd0, chg_flag}, 8'h01);
        check("R10 wake follows flag", {7'd0, wake_req}, 8'h01);
        bus_read(2'd3, rd);
        check("R1 flag register bit 0", rd, 8'h01);
        bus_write(2'd3, 8'h01);
        check("R8 clear loses to live mismatch", {7'd0, chg_flag}, 8'h01);
        bus_read(2'd0, rd);
        bus_write(2'd3, 8'h01);
        check("R9 clear after read", {7'd0, chg_flag}, 8'h00);
        cyc(3);
        check("R9 flag stays clear", {7'd0, chg_flag}, 8'h00);

        bus_write(2'd0, 8'h3C);
        check("R2 latch drives pad_out", pad_out, 8'h3C);
        bus_write(2'd1, 8'h0F);
        check("R3 pad_oe inverse of dir", pad_oe, 8'hF0);
        bus_read(2'd1, rd);
        check("R3 dir read back", rd, 8'h0F);
        bus_write(2'd2, 8'h00);
        check("R4 pull-ups on inputs only", pad_pull, 8'h0F);
        bus_write(2'd2, 8'h01);
        check("R4 pull-ups off", pad_pull, 8'h00);

        @(negedge clk); pad_in = 8'hF0;
        cyc(5);
        check("R7 output pins and low pins ignored", {7'd0, chg_flag}, 8'h00);
        bus_write(2'd1, 8'hFF);
        cyc(2);
        check("R6 input again sees stale snapshot", {7'd0, chg_flag}, 8'h01);
        bus_read(2'd0, rd);
        bus_write(2'd3, 8'h01);
        check("R9 cleared", {7'd0, chg_flag}, 8'h00);
        @(negedge clk); pad_in = 8'hFF;
        cyc(5);
        check("R7 low nibble change ignored", {7'd0, chg_flag}, 8'h00);

        @(negedge clk); pad_in = 8'h0F;
        cyc(4);
        check("R6 flag after upper change", {7'd0, chg_flag}, 8'h01);
        bus_write(2'd0, 8'h81);
        bus_write(2'd3, 8'h01);
        check("R9 port write retakes snapshot", {7'd0, chg_flag}, 8'h00);

        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            bus_addr  = 2'($urandom_range(0, 3));
            bus_wdata = 8'($urandom);
            bus_wr    = ($urandom_range(0, 3) == 0);
            bus_rd    = !bus_wr && ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 7) == 0) pad_in = 8'($urandom);
        end
        @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
        cyc(3);
        finish_run();
    end
endmodule